// File: doc/BRIEF.md
# Dual Interval Timer with Reload Latch and Interrupt Flags

This block holds two 16-bit down-counters behind a byte-wide register bus. Both counters step down once for each cycle in which the tick enable input is high. The first counter reloads from a programmable latch each time it expires. When the mode register selects continuous operation, each expiry raises an interrupt flag. The second counter is a plain free-running down-counter with no interrupt.

Software loads a count one byte at a time. A byte write replaces only that half, and the other half keeps its live value at that moment. The new value goes into the counter at once.

The first expiry comes count+1 ticks after a load. After that, expiries come every latch ticks, so the phase of the original load is kept. Interrupts from the first counter and from an external shift-transfer event are stored as flags. Each flag has an enable bit, and together they drive one active-high interrupt output.

Top module: `latched_timer_pair`

## Requirements
- R1: After reset, both counters read 0xFFFF, the latch reads 0x0000, the mode register reads 0x00, the flag register reads 0x00 and the enable register reads 0xC4. A latch value of 0 stands for a period of 65536 ticks, so the first counter first expires on the 65536th tick.
- R2: A write to offset 4 (low byte) or offset 5 (high byte) loads the first counter. The written byte replaces that half and the other half keeps its current live value. Reads of offsets 4 and 5 return the low and high bytes of the live count.
- R3: Writes to offset 6 (low) and offset 7 (high) set the latch and leave the running counter unchanged. Both offsets read back the latch bytes.
- R4: Counting depends on the count N loaded and the latch L. With the counter at N and the mode set to continuous, the first expiry happens on tick N+1. Later expiries happen every L ticks after that. On each expiry the counter reloads to L-1 (L=0 means 65536).
- R5: The mode register is at offset 11. Expiries set flag bit 6 only when mode bits 7:6 equal 01. With any other mode value the counter still counts and reloads, and no flag is set, including for a load made before the mode was left.
- R6: Flag bit 6 clears when offset 4 is read, when offset 5 is written, or when a 1 is written to bit 6 of the flag register (offset 13). Writing 1 to another bit of the flag register does not clear bit 6.
- R7: The interrupt output is high exactly when a flag bit (6 or 2) and its enable bit are both set. Reading the flag register returns the interrupt output in bit 7 and the flags in bits 6:0.
- R8: A write to the enable register (offset 14) with bit 7 = 1 sets the enables whose data bits are 1. With bit 7 = 0 it clears the enables whose data bits are 1. Reads return 1 in bit 7 and the enables in bits 6:0.
- R9: The second counter is loaded at offsets 8 (low) and 9 (high) with the same rule of keeping the live other half. It reads back at the same offsets and wraps from 0 to 0xFFFF. It never sets a flag.
- R10: A one-cycle pulse on `xfer_done` sets flag bit 2. A 1 written to bit 2 of the flag register clears it.
- R11: The mode register reads back the full byte last written.
- R12: A counter load and a tick in the same cycle leave the loaded value in the counter, not decremented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one pulse per timer tick |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has side effects at offset 4) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| xfer_done | input | 1 | Shift-transfer completion pulse, sets flag bit 2 |
| irq | output | 1 | Active-high interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is the reset latch value of 65536 ticks. The bench holds the tick enable high for 65535 cycles, checks that the counter sits at zero with no flag, and then gives the single tick that must expire and reload to 0xFFFF. The second is the phase of expiries after a load. For this the bench sweeps every small load count against every small latch value, ticks one step at a time, and compares the flag and the count after each tick with the arithmetic schedule. Leaving continuous mode partway through a countdown is reached by changing the mode between two single ticks.

// File: rtl/ltp_pkg.sv
package ltp_pkg;

   localparam int BYTE_W = 8;
   localparam int ADDR_W = 4;
   localparam int FLAG_W = 7;

   // register offsets (bus decode)
   localparam logic [ADDR_W-1:0] OFS_T1_LO  = 4'd4;
   localparam logic [ADDR_W-1:0] OFS_T1_HI  = 4'd5;
   localparam logic [ADDR_W-1:0] OFS_LAT_LO = 4'd6;
   localparam logic [ADDR_W-1:0] OFS_LAT_HI = 4'd7;
   localparam logic [ADDR_W-1:0] OFS_T2_LO  = 4'd8;
   localparam logic [ADDR_W-1:0] OFS_T2_HI  = 4'd9;
   localparam logic [ADDR_W-1:0] OFS_MODE   = 4'd11;
   localparam logic [ADDR_W-1:0] OFS_FLAG   = 4'd13;
   localparam logic [ADDR_W-1:0] OFS_ENA    = 4'd14;

   // interrupt source bit positions
   localparam int BIT_SR = 2;
   localparam int BIT_T1 = 6;
   localparam logic [FLAG_W-1:0] SRC_MASK = FLAG_W'((1 << BIT_T1) | (1 << BIT_SR));

   // timer 1 mode field in mode register bits 7:6
   localparam logic [1:0] MODE_CONT = 2'b01;

   typedef struct packed {
      logic lo;
      logic hi;
   } byte_wr_t;

endpackage

// File: rtl/ltp_counter.sv
module ltp_counter
   import ltp_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int PART_W  = 8,
   parameter logic [CNT_W-1:0] RST_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  byte_wr_t          wr,
   input  logic [PART_W-1:0] wbyte,
   input  logic [CNT_W-1:0]  reload,
   output logic [CNT_W-1:0]  count
);

   localparam int HI_W = CNT_W - PART_W;

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] merged;
   logic             load;

   generate
      if (HI_W != PART_W) begin : g_bad_split
         $error("ltp_counter: CNT_W must be twice PART_W");
      end
   endgenerate

   assign load = wr.lo | wr.hi;

   always_comb begin
      merged = count_q;
      if (wr.lo) merged = {count_q[CNT_W-1:PART_W], wbyte};
      else if (wr.hi) merged = {wbyte, count_q[PART_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= RST_VAL;
      end else if (load) begin
         count_q <= merged;
      end else if (tick) begin
         if (count_q == '0) count_q <= reload;
         else               count_q <= count_q - 1'b1;
      end
   end

   assign count = count_q;

endmodule

// File: rtl/ltp_latch.sv
module ltp_latch
   import ltp_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int PART_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  byte_wr_t          wr,
   input  logic [PART_W-1:0] wbyte,
   output logic [CNT_W-1:0]  latch,
   output logic [CNT_W-1:0]  reload
);

   // zero encodes the full period of 2**CNT_W ticks
   logic [CNT_W-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (wr.lo) begin
         latch_q <= {latch_q[CNT_W-1:PART_W], wbyte};
      end else if (wr.hi) begin
         latch_q <= {wbyte, latch_q[PART_W-1:0]};
      end
   end

   assign latch  = latch_q;
   assign reload = latch_q - 1'b1;

endmodule

// File: rtl/ltp_irq.sv
module ltp_irq
   import ltp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              t1_set,
   input  logic              sr_set,
   input  logic              t1_clr,
   input  logic              flag_wr,
   input  logic              ena_wr,
   input  logic [BYTE_W-1:0] wbyte,
   output logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] enables,
   output logic              irq
);

   logic [FLAG_W-1:0] flags_q, ena_q;
   logic [FLAG_W-1:0] set_vec, clr_vec;

   always_comb begin
      set_vec         = '0;
      set_vec[BIT_T1] = t1_set;
      set_vec[BIT_SR] = sr_set;
      clr_vec         = flag_wr ? wbyte[FLAG_W-1:0] : '0;
      clr_vec[BIT_T1] = clr_vec[BIT_T1] | t1_clr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         ena_q   <= SRC_MASK;
      end else begin
         flags_q <= ((flags_q & ~clr_vec) | set_vec) & SRC_MASK;
         if (ena_wr) begin
            if (wbyte[BYTE_W-1]) ena_q <= (ena_q | wbyte[FLAG_W-1:0]) & SRC_MASK;
            else                 ena_q <= ena_q & ~wbyte[FLAG_W-1:0];
         end
      end
   end

   assign flags   = flags_q;
   assign enables = ena_q;
   assign irq     = |(flags_q & ena_q);

endmodule

// File: rtl/ltp_regs.sv
module ltp_regs
   import ltp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  t1_count,
   input  logic [CNT_W-1:0]  t2_count,
   input  logic [CNT_W-1:0]  t1_latch,
   input  logic [FLAG_W-1:0] flags,
   input  logic [FLAG_W-1:0] enables,
   input  logic              irq,
   output byte_wr_t [1:0]    cnt_wr,
   output byte_wr_t          lat_wr,
   output logic              flag_wr,
   output logic              ena_wr,
   output logic              t1_clr,
   output logic [BYTE_W-1:0] mode_q,
   output logic [BYTE_W-1:0] rdata
);

   logic mode_wr;

   always_comb begin
      cnt_wr[0].lo = bus_wr && (bus_addr == OFS_T1_LO);
      cnt_wr[0].hi = bus_wr && (bus_addr == OFS_T1_HI);
      cnt_wr[1].lo = bus_wr && (bus_addr == OFS_T2_LO);
      cnt_wr[1].hi = bus_wr && (bus_addr == OFS_T2_HI);
      lat_wr.lo    = bus_wr && (bus_addr == OFS_LAT_LO);
      lat_wr.hi    = bus_wr && (bus_addr == OFS_LAT_HI);
      mode_wr      = bus_wr && (bus_addr == OFS_MODE);
      flag_wr      = bus_wr && (bus_addr == OFS_FLAG);
      ena_wr       = bus_wr && (bus_addr == OFS_ENA);
      t1_clr       = (bus_rd && (bus_addr == OFS_T1_LO)) || cnt_wr[0].hi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= '0;
      else if (mode_wr) mode_q <= bus_wdata;
   end

   always_comb begin
      unique case (bus_addr)
         OFS_T1_LO:  rdata = t1_count[BYTE_W-1:0];
         OFS_T1_HI:  rdata = t1_count[CNT_W-1:BYTE_W];
         OFS_LAT_LO: rdata = t1_latch[BYTE_W-1:0];
         OFS_LAT_HI: rdata = t1_latch[CNT_W-1:BYTE_W];
         OFS_T2_LO:  rdata = t2_count[BYTE_W-1:0];
         OFS_T2_HI:  rdata = t2_count[CNT_W-1:BYTE_W];
         OFS_MODE:   rdata = mode_q;
         OFS_FLAG:   rdata = {irq, flags};
         OFS_ENA:    rdata = {1'b1, enables};
         default:    rdata = '0;
      endcase
   end

endmodule

// File: rtl/latched_timer_pair.sv
module latched_timer_pair
   import ltp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [3:0]        bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              xfer_done,
   output logic              irq
);

   localparam int NUM_TMR = 2;

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("latched_timer_pair: CNT_W must span exactly two bus bytes");
      end
   endgenerate

   byte_wr_t [NUM_TMR-1:0] cnt_wr;
   byte_wr_t               lat_wr;
   logic [NUM_TMR-1:0][CNT_W-1:0] cnt;
   logic [NUM_TMR-1:0][CNT_W-1:0] rld;
   logic [CNT_W-1:0]  t1_count, t2_count, t1_latch, t1_reload;
   logic [FLAG_W-1:0] flags, enables;
   logic [BYTE_W-1:0] mode_q;
   logic flag_wr, ena_wr, t1_clr;
   logic t1_load, t1_expire, t1_cont;

   generate
      for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
         if (i == 0) begin : g_reload_latch
            assign rld[i] = t1_reload;
         end else begin : g_reload_full
            assign rld[i] = '1;
         end
         ltp_counter #(
            .CNT_W  (CNT_W),
            .PART_W (BYTE_W)
         ) cnt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_en),
            .wr     (cnt_wr[i]),
            .wbyte  (bus_wdata),
            .reload (rld[i]),
            .count  (cnt[i])
         );
      end
   endgenerate

   assign t1_count = cnt[0];
   assign t2_count = cnt[1];

   ltp_latch #(
      .CNT_W  (CNT_W),
      .PART_W (BYTE_W)
   ) latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (lat_wr),
      .wbyte  (bus_wdata),
      .latch  (t1_latch),
      .reload (t1_reload)
   );

   assign t1_load   = cnt_wr[0].lo | cnt_wr[0].hi;
   assign t1_expire = tick_en && (t1_count == '0) && !t1_load;
   assign t1_cont   = (mode_q[BYTE_W-1:BYTE_W-2] == MODE_CONT);

   ltp_irq irq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .t1_set  (t1_expire && t1_cont),
      .sr_set  (xfer_done),
      .t1_clr  (t1_clr),
      .flag_wr (flag_wr),
      .ena_wr  (ena_wr),
      .wbyte   (bus_wdata),
      .flags   (flags),
      .enables (enables),
      .irq     (irq)
   );

   ltp_regs #(
      .CNT_W (CNT_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .t1_count  (t1_count),
      .t2_count  (t2_count),
      .t1_latch  (t1_latch),
      .flags     (flags),
      .enables   (enables),
      .irq       (irq),
      .cnt_wr    (cnt_wr),
      .lat_wr    (lat_wr),
      .flag_wr   (flag_wr),
      .ena_wr    (ena_wr),
      .t1_clr    (t1_clr),
      .mode_q    (mode_q),
      .rdata     (bus_rdata)
   );

endmodule

// File: rtl/ltp_chk.sv
module ltp_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tick_en,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [3:0]  bus_addr,
   input logic [7:0]  bus_wdata,
   input logic        irq,
   input logic [15:0] t1_count,
   input logic [15:0] t2_count,
   input logic [15:0] t1_latch,
   input logic        t1_flag,
   input logic        sr_flag,
   input logic [7:0]  mode_q
);

   logic t1_wr, t2_wr, lat_wr;
   logic [15:0] lat_m1;

   assign t1_wr  = bus_wr && (bus_addr == 4'd4 || bus_addr == 4'd5);
   assign t2_wr  = bus_wr && (bus_addr == 4'd8 || bus_addr == 4'd9);
   assign lat_wr = bus_wr && (bus_addr == 4'd6 || bus_addr == 4'd7);
   assign lat_m1 = t1_latch - 16'd1;

   AST_T1_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !t1_wr && t1_count != 16'd0) |=> (t1_count == $past(t1_count) - 16'd1)); // R4

   AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !t1_wr && !lat_wr && t1_count == 16'd0) |=> (t1_count == $past(lat_m1))); // R4

   AST_LATCH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_wr && !tick_en) |=> $stable(t1_count)); // R3

   AST_FLAG_ONLY_CONT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(t1_flag) |-> ($past(mode_q[7:6]) == 2'b01)); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == 4'd4 && !(tick_en && t1_count == 16'd0)) |=> !t1_flag); // R6

   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (t1_flag || sr_flag)); // R7

   AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 4'd4) |=> (t1_count[7:0] == $past(bus_wdata))); // R12

   AST_T2_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !t2_wr && t2_count == 16'd0) |=> (t2_count == 16'hFFFF)); // R9

endmodule

bind latched_timer_pair ltp_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .t1_count  (t1_count),
   .t2_count  (t2_count),
   .t1_latch  (t1_latch),
   .t1_flag   (flags[6]),
   .sr_flag   (flags[2]),
   .mode_q    (mode_q)
);

// File: tb/latched_timer_pair_tb_top.sv
`timescale 1ns/1ps
module latched_timer_pair_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [3:0] bus_addr = 4'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       xfer_done = 1'b0;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   latched_timer_pair dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .xfer_done (xfer_done),
      .irq       (irq)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0;
   endtask

   task automatic wr_tick(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_en = 1'b1;
      @(posedge clk); #1 bus_wr = 1'b0; tick_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
      logic [7:0] v;
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(posedge clk); #1 bus_rd = 1'b0;
      check(req, int'(v), exp);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(posedge clk);
      #1 tick_en = 1'b0;
   endtask

   task automatic pulse_xfer();
      @(negedge clk);
      xfer_done = 1'b1;
      @(posedge clk); #1 xfer_done = 1'b0;
   endtask

   task automatic irq_chk(input int exp, input string req);
      @(negedge clk);
      check(req, int'(irq), exp);
   endtask

   task automatic load_t1(input int n);
      wr(4'd5, 8'(n >> 8));
      wr(4'd4, 8'(n));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd_chk(4'd4, 8'hFF, "R1 t1 lo");
      rd_chk(4'd5, 8'hFF, "R1 t1 hi");
      rd_chk(4'd8, 8'hFF, "R1 t2 lo");
      rd_chk(4'd9, 8'hFF, "R1 t2 hi");
      rd_chk(4'd6, 8'h00, "R1 latch lo");
      rd_chk(4'd7, 8'h00, "R1 latch hi");
      rd_chk(4'd11, 8'h00, "R1 mode");
      rd_chk(4'd13, 8'h00, "R1 flags");
      rd_chk(4'd14, 8'hC4, "R1 enables");

      // R1 full reset period: expiry on tick 65536
      wr(4'd11, 8'h40);
      ticks(65535);
      rd_chk(4'd13, 8'h00, "R1 no flag before period");
      rd_chk(4'd5, 8'h00, "R1 count hi at zero");
      ticks(1);
      rd_chk(4'd13, 8'hC0, "R1 flag at tick 65536");
      rd_chk(4'd5, 8'hFF, "R1 reload hi");
      rd_chk(4'd4, 8'hFF, "R1 reload lo");

      // R11 mode readback
      wr(4'd11, 8'h5A);
      rd_chk(4'd11, 8'h5A, "R11 mode readback");
      wr(4'd11, 8'h00);

      // R2 byte merge with live count
      wr(4'd4, 8'h34);
      rd_chk(4'd5, 8'hFF, "R2 hi kept");
      rd_chk(4'd4, 8'h34, "R2 lo written");
      wr(4'd5, 8'h12);
      rd_chk(4'd5, 8'h12, "R2 hi written");
      rd_chk(4'd4, 8'h34, "R2 lo kept");
      ticks(8'h35);
      rd_chk(4'd5, 8'h11, "R2 live hi after ticks");
      rd_chk(4'd4, 8'hFF, "R2 live lo after ticks");
      wr(4'd4, 8'hAA);
      rd_chk(4'd5, 8'h11, "R2 merge keeps live hi");
      rd_chk(4'd4, 8'hAA, "R2 merge lo");
      wr(4'd5, 8'h22);

      // R12 load wins over tick
      wr_tick(4'd4, 8'h07);
      rd_chk(4'd4, 8'h07, "R12 load not decremented");
      rd_chk(4'd5, 8'h22, "R12 hi kept");
      ticks(1);
      rd_chk(4'd4, 8'h06, "R12 next tick decrements");

      // R3 latch writes leave counter alone
      wr(4'd6, 8'h99);
      wr(4'd7, 8'h01);
      rd_chk(4'd4, 8'h06, "R3 count lo unchanged");
      rd_chk(4'd5, 8'h22, "R3 count hi unchanged");
      rd_chk(4'd6, 8'h99, "R3 latch lo");
      rd_chk(4'd7, 8'h01, "R3 latch hi");

      // R4 sweep of load count and latch period
      wr(4'd11, 8'h40);
      for (int n = 0; n <= 4; n++) begin
         for (int l = 1; l <= 4; l++) begin
            wr(4'd6, 8'(l));
            wr(4'd7, 8'h00);
            load_t1(n);
            for (int k = 1; k <= 12; k++) begin
               int exp_cnt;
               bit exp_flag;
               exp_flag = (k >= n + 1) && (((k - n - 1) % l) == 0);
               exp_cnt  = (k <= n) ? (n - k) : (l - 1 - ((k - n - 1) % l));
               ticks(1);
               rd_chk(4'd13, exp_flag ? 8'hC0 : 8'h00, "R4 expiry schedule");
               rd_chk(4'd4, exp_cnt, "R4 count value");
            end
         end
      end

      // R5 no flag outside continuous mode
      wr(4'd11, 8'h00);
      wr(4'd6, 8'h03);
      load_t1(2);
      for (int k = 1; k <= 8; k++) begin
         ticks(1);
         rd_chk(4'd13, 8'h00, "R5 mode 00 no flag");
      end
      rd_chk(4'd4, 8'h00, "R5 count still runs");
      wr(4'd11, 8'hC0);
      load_t1(0);
      ticks(1);
      rd_chk(4'd13, 8'h00, "R5 mode 11 no flag");
      rd_chk(4'd4, 8'h02, "R5 reload in mode 11");
      wr(4'd11, 8'h40);
      load_t1(3);
      ticks(3);
      wr(4'd11, 8'h00);
      ticks(1);
      rd_chk(4'd13, 8'h00, "R5 leaving mode cancels");
      rd_chk(4'd4, 8'h02, "R5 count reloaded");

      // R6 flag clearing paths
      wr(4'd11, 8'h40);
      wr(4'd6, 8'h01);
      load_t1(0);
      ticks(1);
      rd_chk(4'd13, 8'hC0, "R6 flag set");
      wr(4'd13, 8'h04);
      rd_chk(4'd13, 8'hC0, "R6 other bit write keeps flag");
      wr(4'd13, 8'h40);
      rd_chk(4'd13, 8'h00, "R6 write one clears");
      ticks(1);
      rd_chk(4'd13, 8'hC0, "R6 flag set again");
      wr(4'd5, 8'h00);
      rd_chk(4'd13, 8'h00, "R6 hi write clears");
      ticks(1);
      rd_chk(4'd4, 8'h00, "R6 lo read");
      rd_chk(4'd13, 8'h00, "R6 lo read clears");

      // R7 R8 R10 interrupt output and enables
      ticks(1);
      wr(4'd11, 8'h00);
      irq_chk(1, "R7 irq with enabled flag");
      wr(4'd14, 8'h40);
      irq_chk(0, "R8 clear enable drops irq");
      rd_chk(4'd14, 8'h84, "R8 enable readback");
      rd_chk(4'd13, 8'h40, "R7 flag bit7 low");
      pulse_xfer();
      irq_chk(1, "R10 shift event raises irq");
      rd_chk(4'd13, 8'hC4, "R10 shift flag set");
      wr(4'd14, 8'h04);
      irq_chk(0, "R8 clear shift enable");
      rd_chk(4'd14, 8'h80, "R8 all enables off");
      wr(4'd14, 8'hC0);
      irq_chk(1, "R8 set enable restores irq");
      rd_chk(4'd14, 8'hC0, "R8 set readback");
      wr(4'd13, 8'h44);
      irq_chk(0, "R7 flags cleared drop irq");
      rd_chk(4'd13, 8'h00, "R10 shift flag cleared");
      wr(4'd14, 8'h84);

      // R9 second counter
      wr(4'd9, 8'h00);
      wr(4'd8, 8'h07);
      rd_chk(4'd9, 8'h00, "R9 t2 hi");
      rd_chk(4'd8, 8'h07, "R9 t2 lo");
      ticks(7);
      rd_chk(4'd8, 8'h00, "R9 t2 at zero");
      ticks(1);
      rd_chk(4'd8, 8'hFF, "R9 t2 wrap lo");
      rd_chk(4'd9, 8'hFF, "R9 t2 wrap hi");
      rd_chk(4'd13, 8'h00, "R9 no flag from t2");
      wr(4'd9, 8'h3C);
      rd_chk(4'd9, 8'h3C, "R9 t2 hi merge");
      rd_chk(4'd8, 8'hFF, "R9 t2 lo kept");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule